// File: doc/BRIEF.md
# Early-Out Iterative Integer Divider

This block divides one 32-bit integer by another and returns both the quotient and the remainder. It handles either signed or unsigned operands, as chosen per operation. It makes one quotient bit per clock with a restoring shift-and-subtract loop. A single-cycle start pulse loads the operands. The block then holds busy high until it raises a one-cycle done pulse, and at that point the results appear on its outputs. They stay there until the next division finishes.

Before the loop begins, the block looks at the upper bytes of the dividend. Whole leading bytes that carry no magnitude need no quotient bits, so the loop skips them. For unsigned operands these are zero bytes. For signed operands they are bytes that only repeat the sign. Each skipped byte shortens the operation by close to eight clocks. The divisor does not affect this decision. An execute stage can start the divide and hold the following stage until done, so small dividends release the stall sooner.

Top module: `earlyOutDivider`

## Requirements
- R1: With isSigned low, quotient = floor(dividend / divisor) and remainder = dividend - quotient*divisor, both taken as unsigned 32-bit values.
- R2: With isSigned high, the quotient is rounded toward zero and the remainder takes the sign of the dividend (two's complement).
- R3: A divisor of zero gives a quotient of 0xFFFFFFFF and a remainder equal to the raw dividend, in both modes, with the normal latency.
- R4: Count the rising edges from the edge that samples an accepted start to the edge after which done reads 1. That count is 34 when the top byte of the dividend is not redundant.
- R5: When k = 1, 2 or 3 leading bytes are redundant, the count from R4 is 35 - 8k, which gives 27, 19 or 11. Unsigned: byte 3 (bits 31:24), then byte 2, then byte 1 are redundant while they are zero, counted down from the top. Signed: byte j is redundant while bits 31 down to 8j-1 are all equal.
- R6: The latency depends only on the dividend and isSigned, never on the divisor.
- R7: busy reads 1 from the cycle after an accepted start until done rises. done is high for exactly one cycle, and busy is 0 during that cycle.
- R8: A start pulse while busy is 1 is ignored. The running operation's result and latency are unchanged.
- R9: quotient and remainder change only on the edge that raises done. Between completions they hold their values.
- R10: After reset, busy and done are 0 and quotient and remainder are 0.
- R11: Signed 0x80000000 divided by 0xFFFFFFFF returns quotient 0x80000000 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; accepted only while busy is 0 |
| isSigned | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | 32 | Dividend, sampled with start |
| divisor | input | 32 | Divisor, sampled with start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Quotient of the last completed division |
| remainder | output | 32 | Remainder of the last completed division |

## Verification
A wrong skip count shows up in two ways. The done pulse moves away from its expected edge, and the quotient loses or gains high bits, so both faults are visible when that operation completes. A fault in the iteration counter or in the state sequencing moves done by at least one clock. A sign or zero-divisor error corrupts only the final correction, and it shows on quotient and remainder on the same edge that raises done. A start accepted while busy would restart the operation. That would move done and replace the result of the running division, and both effects can be seen before the following completion.

// File: rtl/divPkg.sv
package divPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ALIGN,
    ST_ITER,
    ST_FIX
  } divState_t;

  // Per-cycle commands from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture raw operands and skip count
    logic prep;   // form operand magnitudes
    logic align;  // pre-shift over redundant bytes
    logic step;   // one restoring iteration
    logic fix;    // sign correction and result register
  } divStrobes_t;
endpackage

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int BYTE     = 8,
  parameter int MAX_SKIP = 3,
  localparam int SKIP_W  = $clog2(MAX_SKIP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobes_t       stb,
  input  logic              isSigned,
  input  logic [WIDTH-1:0]  dividend,
  input  logic [WIDTH-1:0]  divisor,
  output logic [SKIP_W-1:0] skipBytes,
  output logic [WIDTH-1:0]  quotient,
  output logic [WIDTH-1:0]  remainder
);
  logic [WIDTH-1:0]  opA, opB, quoR, remR, divMag;
  logic              sgnMode;
  logic [SKIP_W-1:0] skipReg, skipCalc;

  // Count redundant leading bytes of the incoming dividend
  always_comb begin
    logic [WIDTH-1:0] diffBits;
    skipCalc = '0;
    diffBits = isSigned ? (dividend ^ {WIDTH{dividend[WIDTH-1]}}) : dividend;
    for (int j = 1; j <= MAX_SKIP; j++) begin
      if (isSigned) begin
        if ((diffBits >> (WIDTH - 1 - BYTE * j)) == '0) skipCalc = SKIP_W'(j);
      end else begin
        if ((diffBits >> (WIDTH - BYTE * j)) == '0) skipCalc = SKIP_W'(j);
      end
    end
  end

  logic negA, negB, zeroDiv;
  assign negA    = sgnMode & opA[WIDTH-1];
  assign negB    = sgnMode & opB[WIDTH-1];
  assign zeroDiv = (opB == '0);

  logic [WIDTH:0]   shifted;
  logic [WIDTH+1:0] trial;
  assign shifted = {remR, quoR[WIDTH-1]};
  assign trial   = {1'b0, shifted} - {2'b0, divMag};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opA       <= '0;
      opB       <= '0;
      sgnMode   <= 1'b0;
      skipReg   <= '0;
      quoR      <= '0;
      remR      <= '0;
      divMag    <= '0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      if (stb.load) begin
        opA     <= dividend;
        opB     <= divisor;
        sgnMode <= isSigned;
        skipReg <= skipCalc;
      end
      if (stb.prep) begin
        remR   <= '0;
        quoR   <= negA ? (~opA + 1'b1) : opA;
        divMag <= negB ? (~opB + 1'b1) : opB;
      end
      if (stb.align) quoR <= quoR << (BYTE * skipReg);
      if (stb.step) begin
        if (!trial[WIDTH+1]) begin
          remR <= trial[WIDTH-1:0];
          quoR <= {quoR[WIDTH-2:0], 1'b1};
        end else begin
          remR <= shifted[WIDTH-1:0];
          quoR <= {quoR[WIDTH-2:0], 1'b0};
        end
      end
      if (stb.fix) begin
        if (zeroDiv) begin
          quotient  <= '1;
          remainder <= opA;
        end else begin
          quotient  <= (negA ^ negB) ? (~quoR + 1'b1) : quoR;
          remainder <= negA ? (~remR + 1'b1) : remR;
        end
      end
    end
  end

  assign skipBytes = skipReg;
endmodule

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int BYTE     = 8,
  parameter int MAX_SKIP = 3,
  localparam int SKIP_W  = $clog2(MAX_SKIP + 1),
  localparam int CNT_W   = $clog2(WIDTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SKIP_W-1:0] skipBytes,
  output divStrobes_t       stb,
  output logic              busy,
  output logic              done
);
  divState_t        state, nextState;
  logic [CNT_W-1:0] iterCnt;

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: if (start) begin
        stb.load  = 1'b1;
        nextState = ST_SETUP;
      end
      ST_SETUP: begin
        stb.prep  = 1'b1;
        nextState = (skipBytes != '0) ? ST_ALIGN : ST_ITER;
      end
      ST_ALIGN: begin
        stb.align = 1'b1;
        nextState = ST_ITER;
      end
      ST_ITER: begin
        stb.step = 1'b1;
        if (iterCnt == CNT_W'(1)) nextState = ST_FIX;
      end
      ST_FIX: begin
        stb.fix   = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= nextState;
      done  <= stb.fix;
      if (state == ST_SETUP)
        iterCnt <= CNT_W'(WIDTH) - CNT_W'(BYTE * int'(skipBytes));
      else if (stb.step)
        iterCnt <= iterCnt - 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/earlyOutDivider.sv
module earlyOutDivider
  import divPkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int BYTE     = 8,
  parameter int MAX_SKIP = 3,
  localparam int SKIP_W  = $clog2(MAX_SKIP + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             isSigned,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  divStrobes_t       stb;
  logic [SKIP_W-1:0] skipBytes;

  divCtrl #(.WIDTH(WIDTH), .BYTE(BYTE), .MAX_SKIP(MAX_SKIP)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .skipBytes(skipBytes),
    .stb(stb), .busy(busy), .done(done)
  );

  divDatapath #(.WIDTH(WIDTH), .BYTE(BYTE), .MAX_SKIP(MAX_SKIP)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor), .skipBytes(skipBytes),
    .quotient(quotient), .remainder(remainder)
  );
endmodule

// File: rtl/divChecker.sv
module divChecker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             isSigned,
  input logic [WIDTH-1:0] dividend,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder
);
  logic [7:0] latCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               latCnt <= '0;
    else if (start && !busy) latCnt <= '0;
    else if (busy)           latCnt <= latCnt + 1'b1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(done) |-> ($stable(quotient) && $stable(remainder))); // R9
  AST_LATENCY_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (latCnt == 8'd34 || latCnt == 8'd27 || latCnt == 8'd19 || latCnt == 8'd11)); // R5
endmodule

bind earlyOutDivider divChecker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/earlyOutDivider_tb.sv
module earlyOutDivider_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isSigned = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done;
  logic [31:0] quotient, remainder;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  earlyOutDivider u_dut (
    .clk(clk), .rstN(rstN), .start(start), .isSigned(isSigned),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int expLatency(input logic [31:0] a, input bit s);
    int k = 0;
    for (int j = 1; j <= 3; j++) begin
      if (s) begin
        logic signed [31:0] t = $signed(a) >>> (31 - 8*j);
        if ((t == 0 || t == -1) && k == j-1) k = j;
      end else begin
        if ((a >> (32 - 8*j)) == 0 && k == j-1) k = j;
      end
    end
    return (k == 0) ? 34 : 35 - 8*k;
  endfunction

  function automatic logic [63:0] refDiv(input logic [31:0] a, input logic [31:0] b, input bit s);
    longint la, lb, q, r;
    if (b == 0) return {32'hFFFF_FFFF, a};
    la = s ? longint'($signed(a)) : longint'({32'b0, a});
    lb = s ? longint'($signed(b)) : longint'({32'b0, b});
    q = la / lb;
    r = la % lb;
    return {q[31:0], r[31:0]};
  endfunction

  task automatic runDiv(input logic [31:0] a, input logic [31:0] b, input bit s,
                        input bit interfere, input string req);
    int lat;
    int expLat;
    logic [63:0] expRes;
    bit seen;
    expLat = expLatency(a, s);
    expRes = refDiv(a, b, s);
    @(negedge clk);
    start = 1'b1; dividend = a; divisor = b; isSigned = s;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && done === 1'b0, "R7", "busy after start", {63'b0, busy}, 64'd1);
    lat = 0; seen = 0;
    while (!seen && lat < 60) begin
      if (interfere && lat == 3) begin
        start = 1'b1; dividend = ~a; divisor = b + 32'd3; isSigned = ~s;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (done === 1'b1) seen = 1;
    end
    start = 1'b0;
    check(seen && lat == expLat, interfere ? "R8" : req, "latency", 64'(lat), 64'(expLat));
    check({quotient, remainder} === expRes, interfere ? "R8" : req, "result",
          {quotient, remainder}, expRes);
    check(busy === 1'b0, "R7", "busy low at done", {63'b0, busy}, 64'd0);
    @(negedge clk);
    check(done === 1'b0, "R7", "done single cycle", {63'b0, done}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && quotient === '0 && remainder === '0,
          "R10", "reset state", {busy, done, quotient, remainder[29:0]}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    runDiv(32'd100, 32'd7, 1'b0, 1'b0, "R1");
    runDiv(32'hFFFF_FFFF, 32'd3, 1'b0, 1'b0, "R1");
    runDiv(32'hDEAD_BEEF, 32'h0001_0000, 1'b0, 1'b0, "R4");
    runDiv(32'h00FF_FFFF, 32'd5, 1'b0, 1'b0, "R5");
    runDiv(32'h0000_ABCD, 32'd9, 1'b0, 1'b0, "R5");
    runDiv(32'h0000_00FF, 32'd2, 1'b0, 1'b0, "R5");
    runDiv(-32'sd100, 32'd7, 1'b1, 1'b0, "R2");
    runDiv(32'd100, -32'sd7, 1'b1, 1'b0, "R2");
    runDiv(-32'sd100, -32'sd7, 1'b1, 1'b0, "R2");
    runDiv(32'hFFFF_FF80, 32'd3, 1'b1, 1'b0, "R5");
    runDiv(32'h0000_0080, 32'd3, 1'b1, 1'b0, "R5");
    runDiv(32'h0080_0000, 32'd3, 1'b1, 1'b0, "R4");
    runDiv(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R11");
    runDiv(32'h1234_5678, 32'd0, 1'b0, 1'b0, "R3");
    runDiv(32'hFFFF_FFF0, 32'd0, 1'b1, 1'b0, "R3");
    runDiv(32'h0000_0042, 32'd0, 1'b0, 1'b0, "R3");
    runDiv(32'h0000_1234, 32'hFFFF_FFFF, 1'b0, 1'b0, "R6");
    runDiv(32'h0000_1234, 32'd1, 1'b0, 1'b0, "R6");
    runDiv(32'h0012_3456, 32'd77, 1'b0, 1'b1, "R8");
    runDiv(32'hFFFF_8000, 32'd11, 1'b1, 1'b1, "R8");

    begin
      logic [31:0] q0, r0;
      q0 = quotient; r0 = remainder;
      repeat (5) @(negedge clk);
      check(quotient === q0 && remainder === r0, "R9", "held results",
            {quotient, remainder}, {q0, r0});
    end

    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b;
      bit s;
      s = $urandom_range(1, 0);
      a = $urandom >> (8 * $urandom_range(3, 0));
      if (s && $urandom_range(1, 0)) a = ~a;
      b = $urandom >> $urandom_range(31, 0);
      if (s && $urandom_range(1, 0)) b = -b;
      runDiv(a, b, s, 1'b0, s ? "R2" : "R1");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule